// File: doc/BRIEF.md
# Volume Ramp Sequencer

This block decides the live setting of a stepped volume attenuator in a stereo audio path. It reads a programmed 5-bit volume code, a software run bit, an active-low hardware shutdown pin, a 2-bit source-select code and a beep request. From these it drives the live volume code, the live source code, a decoded per-source enable vector, the amplifier enable, the beep routing select and a busy flag. The analog attenuator, the amplifiers and the beep gain are outside the block. It produces only codes and enables.

The live volume never jumps. A request to shut down, a return from shutdown, a change of source or a change of the programmed volume all move the live code one step per step period until it reaches its target. When the source changes, the volume fades to mute, the new source is loaded while the path is silent, and the volume rises again to the stored code. When either shutdown control becomes inactive, the volume fades to mute before the amplifier is switched off. The step period is a parameter counted in clock cycles (1.5 ms of the system clock by default), so a testbench can shorten it.

Top module: `volRampSeq`

## Requirements
- R1: Under reset, liveVol is 0, liveSrc is 00, srcOn is 001, ampEnable is 0 and beepRoute is 0. With swEnable low after reset, busy is 0.
- R2: The live volume code moves by exactly one code per change. A step happens STEP_CYCLES clock edges after the target first differs from liveVol, and every STEP_CYCLES edges after that until the target is reached. Code 0 is full mute and 31 is the loudest.
- R3: ampEnable rises one edge after hwShdnN and swEnable are both 1. When either one goes to 0, liveVol ramps to 0, and ampEnable falls only while liveVol is 0.
- R4: On leaving shutdown, liveVol ramps up from 0 to the value on volReg.
- R5: When srcReg differs from liveSrc, liveVol ramps to 0 and liveSrc then takes srcReg. liveVol then ramps back to volReg. liveSrc changes only while liveVol is 0.
- R6: srcOn decodes liveSrc as follows: 00 gives 001, 01 gives 010, 10 gives 100, and 11 gives 111, which sums all three sources.
- R7: beepRoute follows beepEnIn one edge later. While beepRoute is 1, srcOn is 000 and liveVol is unaffected. When beepRoute returns to 0, the decoded enables come back.
- R8: While in shutdown, changes on volReg and srcReg do not raise liveVol above 0. The held value of volReg is the target at shutdown exit.
- R9: With no shutdown or source change in progress, a new volReg value is approached one step per STEP_CYCLES edges.
- R10: A new target that arrives mid-ramp continues from the current live code. The step timer is not restarted.
- R11: busy is 1 whenever liveVol differs from its target, a source change is pending, or ampEnable disagrees with the run condition. Every change of liveVol happens while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| volReg | input | 5 | Programmed volume code (0 = mute) |
| swEnable | input | 1 | Software run bit, 1 = run |
| hwShdnN | input | 1 | Hardware shutdown pin, active low |
| srcReg | input | 2 | Programmed source select (11 = mix all) |
| beepEnIn | input | 1 | Beep routing request |
| liveVol | output | 5 | Live attenuator code |
| liveSrc | output | 2 | Live source code |
| srcOn | output | 3 | Per-source path enables |
| ampEnable | output | 1 | Amplifier enable |
| beepRoute | output | 1 | Beep drives both outputs |
| busy | output | 1 | A ramp or switch is in progress |

## Verification
The bound checker checks the local rules on every cycle. The live code moves only in unit steps and only while busy. The source code changes only at mute. The amplifier switches off only at mute and switches on only when both run conditions were present. The amplifier stays off only with the volume muted. The bench's scenarios alone can show the timing and the end points. These are the exact edge of the first step, a reversal mid-ramp that keeps the timer phase, the down-switch-up sequence for each source code, the beep override, and register values held through shutdown that are reached again on exit.

// File: rtl/volRampPkg.sv
package volRampPkg;
  typedef struct packed {
    logic stepUp;
    logic stepDn;
    logic loadSrc;
    logic ampOn;
    logic ampOff;
  } rampStrobes_t;
endpackage

// File: rtl/volRampCtl.sv
module volRampCtl
  import volRampPkg::*;
#(
  parameter int VOL_W       = 5,
  parameter int SRC_W       = 2,
  parameter int STEP_CYCLES = 72000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [VOL_W-1:0] volReg,
  input  logic             swEnable,
  input  logic             hwShdnN,
  input  logic [SRC_W-1:0] srcReg,
  input  logic [VOL_W-1:0] liveVol,
  input  logic [SRC_W-1:0] liveSrc,
  input  logic             ampEnable,
  output rampStrobes_t     strobes,
  output logic             busy
);
  localparam int CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CYCLES - 1);

  logic             runOk;
  logic             srcPend;
  logic [VOL_W-1:0] target;
  logic             atTarget;
  logic             tick;
  logic [CNT_W-1:0] stepCnt;

  // one shared target: mute for shutdown or source change, else the register
  always_comb begin
    runOk    = hwShdnN & swEnable;
    srcPend  = (srcReg != liveSrc);
    target   = (!runOk || srcPend) ? '0 : volReg;
    atTarget = (liveVol == target);
    tick     = !atTarget && (stepCnt == LAST);
  end

  // step timer idles at zero and keeps its phase across retargets
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          stepCnt <= '0;
    else if (atTarget)  stepCnt <= '0;
    else if (tick)      stepCnt <= '0;
    else                stepCnt <= stepCnt + CNT_W'(1);
  end

  always_comb begin
    strobes.stepUp  = tick && (liveVol < target);
    strobes.stepDn  = tick && (liveVol > target);
    strobes.loadSrc = srcPend && (liveVol == '0);
    strobes.ampOn   = runOk && !ampEnable;
    strobes.ampOff  = !runOk && ampEnable && (liveVol == '0);
    busy            = !atTarget || srcPend || (ampEnable != runOk);
  end
endmodule

// File: rtl/volRampDp.sv
module volRampDp
  import volRampPkg::*;
#(
  parameter int VOL_W = 5,
  parameter int SRC_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  rampStrobes_t       strobes,
  input  logic [SRC_W-1:0]   srcReg,
  input  logic               beepEnIn,
  output logic [VOL_W-1:0]   liveVol,
  output logic [SRC_W-1:0]   liveSrc,
  output logic [(1<<SRC_W)-2:0] srcOn,
  output logic               ampEnable,
  output logic               beepRoute
);
  localparam int NUM_SRC = (1 << SRC_W) - 1;
  localparam logic [SRC_W-1:0] MIX_ALL = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveVol   <= '0;
      liveSrc   <= '0;
      ampEnable <= 1'b0;
      beepRoute <= 1'b0;
    end else begin
      if (strobes.stepUp)      liveVol <= liveVol + VOL_W'(1);
      else if (strobes.stepDn) liveVol <= liveVol - VOL_W'(1);
      if (strobes.loadSrc)     liveSrc <= srcReg;
      if (strobes.ampOn)       ampEnable <= 1'b1;
      else if (strobes.ampOff) ampEnable <= 1'b0;
      beepRoute <= beepEnIn;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : gSrcDec
    assign srcOn[i] = !beepRoute &&
                      ((liveSrc == SRC_W'(i)) || (liveSrc == MIX_ALL));
  end
endmodule

// File: rtl/volRampSeq.sv
module volRampSeq
  import volRampPkg::*;
#(
  parameter int VOL_W       = 5,
  parameter int SRC_W       = 2,
  parameter int STEP_CYCLES = 72000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [VOL_W-1:0] volReg,
  input  logic             swEnable,
  input  logic             hwShdnN,
  input  logic [SRC_W-1:0] srcReg,
  input  logic             beepEnIn,
  output logic [VOL_W-1:0] liveVol,
  output logic [SRC_W-1:0] liveSrc,
  output logic [(1<<SRC_W)-2:0] srcOn,
  output logic             ampEnable,
  output logic             beepRoute,
  output logic             busy
);
  rampStrobes_t strobes;

  volRampCtl #(.VOL_W(VOL_W), .SRC_W(SRC_W), .STEP_CYCLES(STEP_CYCLES)) uCtl (
    .clk(clk), .rstN(rstN), .volReg(volReg), .swEnable(swEnable),
    .hwShdnN(hwShdnN), .srcReg(srcReg), .liveVol(liveVol),
    .liveSrc(liveSrc), .ampEnable(ampEnable), .strobes(strobes), .busy(busy)
  );

  volRampDp #(.VOL_W(VOL_W), .SRC_W(SRC_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .srcReg(srcReg),
    .beepEnIn(beepEnIn), .liveVol(liveVol), .liveSrc(liveSrc),
    .srcOn(srcOn), .ampEnable(ampEnable), .beepRoute(beepRoute)
  );
endmodule

// File: rtl/volRampSeqChk.sv
module volRampSeqChk #(
  parameter int VOL_W = 5,
  parameter int SRC_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             swEnable,
  input logic             hwShdnN,
  input logic [VOL_W-1:0] liveVol,
  input logic [SRC_W-1:0] liveSrc,
  input logic             ampEnable,
  input logic             busy
);
  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(liveVol) |-> ((liveVol - $past(liveVol)) == VOL_W'(1)) ||
                          (($past(liveVol) - liveVol) == VOL_W'(1)));

  a_r11_move_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(liveVol) |-> $past(busy));

  a_r5_switch_at_mute: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(liveSrc) |-> (liveVol == '0) && ($past(liveVol) == '0));

  a_r3_off_at_mute: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ampEnable) |-> ($past(liveVol) == '0));

  a_r3_on_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ampEnable) |-> $past(hwShdnN && swEnable));

  a_r8_silent_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !ampEnable |-> (liveVol == '0));
endmodule

bind volRampSeq volRampSeqChk #(.VOL_W(VOL_W), .SRC_W(SRC_W)) uChk (
  .clk(clk), .rstN(rstN), .swEnable(swEnable), .hwShdnN(hwShdnN),
  .liveVol(liveVol), .liveSrc(liveSrc), .ampEnable(ampEnable), .busy(busy)
);

// File: tb/tb_volRampSeq.sv
module tb_volRampSeq;
  localparam int CLK_PERIOD = 10;
  localparam int STEP = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] volReg = '0;
  logic       swEnable = 1'b0;
  logic       hwShdnN = 1'b1;
  logic [1:0] srcReg = '0;
  logic       beepEnIn = 1'b0;
  logic [4:0] liveVol;
  logic [1:0] liveSrc;
  logic [2:0] srcOn;
  logic       ampEnable, beepRoute, busy;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  volRampSeq #(.STEP_CYCLES(STEP)) dut (
    .clk(clk), .rstN(rstN), .volReg(volReg), .swEnable(swEnable),
    .hwShdnN(hwShdnN), .srcReg(srcReg), .beepEnIn(beepEnIn),
    .liveVol(liveVol), .liveSrc(liveSrc), .srcOn(srcOn),
    .ampEnable(ampEnable), .beepRoute(beepRoute), .busy(busy)
  );

  typedef struct packed {
    logic [4:0] vol; logic en; logic hw; logic [1:0] src; logic beep;
    logic [7:0] waitCyc;
    logic [4:0] eVol; logic [1:0] eSrc; logic eAmp; logic eBeep;
    logic eBusy; logic [2:0] eOn;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{5'd10, 1'b1, 1'b1, 2'd0, 1'b0, 8'd50,  5'd10, 2'd0, 1'b1, 1'b0, 1'b0, 3'b001}, // R4 R6
    '{5'd6,  1'b1, 1'b1, 2'd0, 1'b0, 8'd30,  5'd6,  2'd0, 1'b1, 1'b0, 1'b0, 3'b001}, // R9
    '{5'd6,  1'b1, 1'b1, 2'd2, 1'b0, 8'd60,  5'd6,  2'd2, 1'b1, 1'b0, 1'b0, 3'b100}, // R5 R6
    '{5'd6,  1'b1, 1'b1, 2'd3, 1'b0, 8'd60,  5'd6,  2'd3, 1'b1, 1'b0, 1'b0, 3'b111}, // R5 R6 mix
    '{5'd6,  1'b1, 1'b1, 2'd3, 1'b1, 8'd3,   5'd6,  2'd3, 1'b1, 1'b1, 1'b0, 3'b000}, // R7
    '{5'd6,  1'b1, 1'b0, 2'd3, 1'b0, 8'd40,  5'd0,  2'd3, 1'b0, 1'b0, 1'b0, 3'b111}, // R3 R7
    '{5'd20, 1'b1, 1'b0, 2'd3, 1'b0, 8'd10,  5'd0,  2'd3, 1'b0, 1'b0, 1'b0, 3'b111}, // R8
    '{5'd20, 1'b1, 1'b1, 2'd3, 1'b0, 8'd100, 5'd20, 2'd3, 1'b1, 1'b0, 1'b0, 3'b111}, // R4 R8
    '{5'd20, 1'b0, 1'b1, 2'd3, 1'b0, 8'd100, 5'd0,  2'd3, 1'b0, 1'b0, 1'b0, 3'b111}, // R3
    '{5'd20, 1'b1, 1'b1, 2'd1, 1'b0, 8'd100, 5'd20, 2'd1, 1'b1, 1'b0, 1'b0, 3'b010}, // R4 R6
    '{5'd31, 1'b1, 1'b1, 2'd1, 1'b0, 8'd60,  5'd31, 2'd1, 1'b1, 1'b0, 1'b0, 3'b010}, // R9 top
    '{5'd0,  1'b1, 1'b1, 2'd1, 1'b0, 8'd140, 5'd0,  2'd1, 1'b1, 1'b0, 1'b0, 3'b010}  // R9 mute
  };

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitors on the negative edge, away from the active edge
  logic [4:0] prevVol = '0;
  logic [1:0] prevSrc = '0;
  logic       prevAmp = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (liveVol != prevVol)
        check("R2 unit step", int'((liveVol > prevVol) ? liveVol - prevVol : prevVol - liveVol), 1);
      if (liveSrc != prevSrc)
        check("R5 switch at mute", int'(liveVol), 0);
      if (prevAmp && !ampEnable)
        check("R3 off only at mute", int'(liveVol), 0);
    end
    prevVol = liveVol;
    prevSrc = liveSrc;
    prevAmp = ampEnable;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    ticks(3);
    check("R1 liveVol", int'(liveVol), 0);
    check("R1 liveSrc", int'(liveSrc), 0);
    check("R1 srcOn", int'(srcOn), 1);
    check("R1 ampEnable", int'(ampEnable), 0);
    check("R1 beepRoute", int'(beepRoute), 0);
    @(negedge clk);
    rstN = 1'b1;
    ticks(2);
    check("R1 busy idle", int'(busy), 0);

    for (int i = 0; i < NV; i++) begin
      volReg = VECS[i].vol; swEnable = VECS[i].en; hwShdnN = VECS[i].hw;
      srcReg = VECS[i].src; beepEnIn = VECS[i].beep;
      ticks(int'(VECS[i].waitCyc));
      check($sformatf("R2 vec%0d liveVol", i), int'(liveVol), int'(VECS[i].eVol));
      check($sformatf("R5 vec%0d liveSrc", i), int'(liveSrc), int'(VECS[i].eSrc));
      check($sformatf("R3 vec%0d ampEnable", i), int'(ampEnable), int'(VECS[i].eAmp));
      check($sformatf("R7 vec%0d beepRoute", i), int'(beepRoute), int'(VECS[i].eBeep));
      check($sformatf("R11 vec%0d busy", i), int'(busy), int'(VECS[i].eBusy));
      check($sformatf("R6 vec%0d srcOn", i), int'(srcOn), int'(VECS[i].eOn));
    end

    // R2: first step exactly STEP edges after the target moves
    volReg = 5'd3;
    ticks(STEP - 1);
    check("R2 no early step", int'(liveVol), 0);
    check("R11 busy mid ramp", int'(busy), 1);
    ticks(1);
    check("R2 first step", int'(liveVol), 1);
    ticks(STEP);
    check("R2 second step", int'(liveVol), 2);
    ticks(STEP + 2);
    check("R9 settled", int'(liveVol), 3);

    // R10: retarget mid-ramp keeps the code and the timer phase
    volReg = 5'd8;
    ticks(2 * STEP);
    check("R10 before retarget", int'(liveVol), 5);
    hwShdnN = 1'b0;
    ticks(STEP - 1);
    check("R10 no jump", int'(liveVol), 5);
    check("R3 amp held while fading", int'(ampEnable), 1);
    ticks(1);
    check("R10 reversed step", int'(liveVol), 4);
    ticks(4 * STEP + 3);
    check("R3 faded to mute", int'(liveVol), 0);
    check("R3 amp off", int'(ampEnable), 0);

    // R3: enable rises one edge after both run conditions hold
    hwShdnN = 1'b1;
    ticks(1);
    check("R3 amp on", int'(ampEnable), 1);
    check("R4 starts from mute", int'(liveVol), 0);
    ticks(8 * STEP + 2);
    check("R4 reached stored code", int'(liveVol), 8);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule